// File: doc/BRIEF.md
# Serial Frame CRC-16 Checker

This block checks the CRC-16 of a received frame, one bit at a time. It sits after the flag hunter and the zero-bit remover of a synchronous serial receiver. It has two modes. The bit-oriented framing mode (SDLC) presets the register to all ones and feeds every bit straight into the register, including both check characters. The byte-synchronous mode presets to all zeros and delays each bit by eight accepted bits before it reaches the register. This delay gives the receive path one character of slack to decide what is covered by the check.

The flag logic brackets each frame with single-cycle strobes. On the frame-end strobe the checker compares its register with the pass value of the current mode and latches the verdict on `crc_error`. It also pulses `crc_done` for one cycle. In the bit-oriented mode the register then presets itself, so the next frame needs no software action. In the byte-synchronous mode the register keeps its value until software resets it. The register is also preset by a software command, by the enter-hunt pulse, or by disabling the receiver.

The serial input is a valid/ready stream. A bit moves when `bit_valid` and `bit_ready` are both high on a rising clock edge. `bit_ready` drops while the receiver is disabled and during a frame-end cycle, and a bit offered then is dropped. The source may hold `bit_valid` and `bit_data` across such cycles or withdraw them; the block does not require either.

Top module: `rx_crc_check`

## Requirements
- R1: Each accepted bit advances the register by one step of the generator x^16 + x^12 + x^5 + 1, in reflected form (the least significant bit of each character is transferred first, and the feedback constant is 0x8408).
- R2: In bit-oriented mode (`sdlc_mode`=1), accepted bits enter the register with no delay. The frame passes when the register holds the residue 0x1D0F, written first-bit-at-bit-15 (0xF0B8 in the reflected register). A frame whose check characters were sent inverted and intact therefore reports `crc_error`=0, and any corrupted frame reports 1.
- R3: In byte-synchronous mode (`sdlc_mode`=0), a bit reaches the register only after eight further bits have been accepted. The frame passes when the register is all zeros. With uninverted check characters followed by eight pad bits the result is a pass; without the pad bits the result depends on the partial register.
- R4: A `crc_reset_cmd` pulse presets the register to all ones in bit-oriented mode and to all zeros in byte-synchronous mode, and it clears the delay line.
- R5: A `hunt_pulse`, or any cycle with `rx_enable` low, presets the register and the delay line in the same way as R4.
- R6: On `frame_end` in bit-oriented mode, the register presets to all ones after the verdict is latched. In byte-synchronous mode `frame_end` leaves the register unchanged.
- R7: `crc_done` is high for exactly the one cycle after each `frame_end` cycle. `crc_error` takes the new verdict on that same edge.
- R8: `crc_error` holds its value until a `frame_start` cycle clears it at the next edge. When `frame_start` and `frame_end` occur in the same cycle, `frame_end` wins.
- R9: `bit_ready` is high only while `rx_enable` is high and `frame_end` is low. A bit offered while `bit_ready` is low changes neither the register nor the delay line.
- R10: After reset, `crc_error` and `crc_done` are 0, the register holds all ones and the delay line holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdlc_mode | input | 1 | 1 = bit-oriented framing, 0 = byte-synchronous |
| rx_enable | input | 1 | Receiver enabled; low presets the checker |
| hunt_pulse | input | 1 | Enter-hunt request; presets the checker |
| crc_reset_cmd | input | 1 | Software preset command |
| frame_start | input | 1 | Opening flag seen; clears the error flag |
| frame_end | input | 1 | Closing flag seen; check point |
| bit_valid | input | 1 | Serial bit offered |
| bit_data | input | 1 | Serial bit value |
| bit_ready | output | 1 | Checker accepts the offered bit |
| crc_error | output | 1 | Verdict of the last checked frame, 1 = bad |
| crc_done | output | 1 | One-cycle strobe after a check point |

## Verification
The bench builds the block with its default parameters: a 16-bit register, generator 0x1021, residue 0x1D0F and an 8-bit byte-synchronous delay. With these values, frames built in the bench with the public X.25-style frame check sequence hit the bit-oriented residue compare. Byte-synchronous frames can be sent with and without the eight trailing pad bits, so the delay line shows up at the verdict. Bit flips are placed both in the data and in the check characters, and presets are driven mid-frame from every source.

// File: rtl/rx_crc_pkg.sv
package rx_crc_pkg;

  typedef enum logic {
    MODE_BYTE_SYNC = 1'b0,
    MODE_BIT_FRAME = 1'b1
  } crc_mode_e;

  typedef struct packed {
    logic sw;    // software, hunt or disable preset
    logic auto;  // end-of-frame preset in bit-oriented mode
  } preset_src_t;

endpackage

// File: rtl/rx_crc_delay.sv
module rx_crc_delay #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic shift,
  input  logic din,
  output logic dout
);

  generate
    if (DEPTH == 0) begin : g_bypass
      assign dout = din;
    end else if (DEPTH == 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stage_q <= 1'b0;
        else if (clear) stage_q <= 1'b0;
        else if (shift) stage_q <= din;
      end
      assign dout = stage_q;
    end else begin : g_chain
      logic [DEPTH-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     chain_q <= '0;
        else if (clear) chain_q <= '0;
        else if (shift) chain_q <= {chain_q[DEPTH-2:0], din};
      end
      // bit leaving the chain is the one accepted DEPTH shifts ago
      assign dout = chain_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/rx_crc_lfsr.sv
module rx_crc_lfsr #(
  parameter int              CRC_W     = 16,
  parameter logic [CRC_W-1:0] POLY_REFL = 16'h8408
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset,
  input  logic [CRC_W-1:0] preset_val,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q
);

  logic             feedback;
  logic [CRC_W-1:0] crc_next;

  always_comb begin
    feedback = crc_q[0] ^ din;
    crc_next = {1'b0, crc_q[CRC_W-1:1]};
    if (feedback) crc_next = crc_next ^ POLY_REFL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '1;
    else if (preset) crc_q <= preset_val;
    else if (step)   crc_q <= crc_next;
  end

endmodule

// File: rtl/rx_crc_result.sv
module rx_crc_result
  import rx_crc_pkg::*;
#(
  parameter int               CRC_W        = 16,
  parameter logic [CRC_W-1:0] RESIDUE_REFL = 16'hF0B8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  crc_mode_e        mode,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic [CRC_W-1:0] crc_q,
  output logic             crc_error,
  output logic             crc_done
);

  logic match;

  always_comb begin
    unique case (mode)
      MODE_BIT_FRAME: match = (crc_q == RESIDUE_REFL);
      default:        match = (crc_q == '0);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_error <= 1'b0;
      crc_done  <= 1'b0;
    end else begin
      crc_done <= frame_end;
      if (frame_end)        crc_error <= ~match;
      else if (frame_start) crc_error <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_crc_check.sv
module rx_crc_check
  import rx_crc_pkg::*;
#(
  parameter int               CRC_W        = 16,
  parameter logic [CRC_W-1:0] POLY         = 16'h1021,
  parameter logic [CRC_W-1:0] SDLC_RESIDUE = 16'h1D0F,
  parameter int               SYNC_DELAY   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdlc_mode,
  input  logic rx_enable,
  input  logic hunt_pulse,
  input  logic crc_reset_cmd,
  input  logic frame_start,
  input  logic frame_end,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  output logic crc_error,
  output logic crc_done
);

  function automatic logic [CRC_W-1:0] bit_reverse(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  localparam logic [CRC_W-1:0] POLY_REFL    = bit_reverse(POLY);
  localparam logic [CRC_W-1:0] RESIDUE_REFL = bit_reverse(SDLC_RESIDUE);

  crc_mode_e        mode;
  preset_src_t      preset_src;
  logic             take;
  logic             preset;
  logic [CRC_W-1:0] preset_val;
  logic             delayed_bit;
  logic             crc_din;
  logic [CRC_W-1:0] crc_q;

  assign mode      = crc_mode_e'(sdlc_mode);
  assign bit_ready = rx_enable & ~frame_end;
  assign take      = bit_valid & bit_ready;

  assign preset_src.sw   = ~rx_enable | hunt_pulse | crc_reset_cmd;
  assign preset_src.auto = frame_end & (mode == MODE_BIT_FRAME);
  assign preset          = |preset_src;
  assign preset_val      = (mode == MODE_BIT_FRAME) ? '1 : '0;

  rx_crc_delay #(
    .DEPTH (SYNC_DELAY)
  ) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (preset),
    .shift (take & (mode == MODE_BYTE_SYNC)),
    .din   (bit_data),
    .dout  (delayed_bit)
  );

  assign crc_din = (mode == MODE_BIT_FRAME) ? bit_data : delayed_bit;

  rx_crc_lfsr #(
    .CRC_W     (CRC_W),
    .POLY_REFL (POLY_REFL)
  ) u_lfsr (
    .clk        (clk),
    .rst_n      (rst_n),
    .preset     (preset),
    .preset_val (preset_val),
    .step       (take),
    .din        (crc_din),
    .crc_q      (crc_q)
  );

  rx_crc_result #(
    .CRC_W        (CRC_W),
    .RESIDUE_REFL (RESIDUE_REFL)
  ) u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .crc_q       (crc_q),
    .crc_error   (crc_error),
    .crc_done    (crc_done)
  );

endmodule

// File: rtl/rx_crc_check_sva.sv
module rx_crc_check_sva #(
  parameter int               CRC_W        = 16,
  parameter logic [CRC_W-1:0] SDLC_RESIDUE = 16'h1D0F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdlc_mode,
  input logic             rx_enable,
  input logic             hunt_pulse,
  input logic             crc_reset_cmd,
  input logic             frame_start,
  input logic             frame_end,
  input logic             crc_error,
  input logic             crc_done,
  input logic [CRC_W-1:0] crc_q
);

  logic [CRC_W-1:0] good_refl;
  always_comb
    for (int i = 0; i < CRC_W; i++) good_refl[i] = SDLC_RESIDUE[CRC_W-1-i];

  p_sdlc_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && sdlc_mode && crc_q == good_refl) |=> !crc_error);

  p_sync_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !sdlc_mode && crc_q == '0) |=> !crc_error);

  p_cmd_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_reset_cmd && sdlc_mode) |=> (crc_q == '1));

  p_cmd_zeros_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_reset_cmd && !sdlc_mode) |=> (crc_q == '0));

  p_hunt_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((hunt_pulse || !rx_enable) && !sdlc_mode) |=> (crc_q == '0));

  p_auto_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && sdlc_mode) |=> (crc_q == '1));

  p_done_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> crc_done);

  p_done_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !crc_done);

  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !frame_end) |=> $stable(crc_error));

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !frame_end) |=> !crc_error);

  p_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !sdlc_mode && rx_enable && !hunt_pulse && !crc_reset_cmd)
      |=> $stable(crc_q));

endmodule

bind rx_crc_check rx_crc_check_sva #(
  .CRC_W        (CRC_W),
  .SDLC_RESIDUE (SDLC_RESIDUE)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .sdlc_mode     (sdlc_mode),
  .rx_enable     (rx_enable),
  .hunt_pulse    (hunt_pulse),
  .crc_reset_cmd (crc_reset_cmd),
  .frame_start   (frame_start),
  .frame_end     (frame_end),
  .crc_error     (crc_error),
  .crc_done      (crc_done),
  .crc_q         (crc_q)
);

// File: tb/rx_crc_check_bench.sv
module rx_crc_check_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdlc_mode = 1'b1, rx_enable = 1'b1, hunt_pulse = 1'b0, crc_reset_cmd = 1'b0;
  logic frame_start = 1'b0, frame_end = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic bit_ready, crc_error, crc_done;

  int total = 0;
  int failed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rx_crc_check u_rx_crc_check (
    .clk (clk), .rst_n (rst_n), .sdlc_mode (sdlc_mode), .rx_enable (rx_enable),
    .hunt_pulse (hunt_pulse), .crc_reset_cmd (crc_reset_cmd),
    .frame_start (frame_start), .frame_end (frame_end),
    .bit_valid (bit_valid), .bit_data (bit_data),
    .bit_ready (bit_ready), .crc_error (crc_error), .crc_done (crc_done)
  );

  // vector: [23] preset cmd first, [22] bit-oriented mode, [21] pad byte,
  // [20:16] data bytes, [15:8] flipped bit index (255 = none), [7:0] seed
  localparam int NVEC = 9;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 5'd4,  8'd255, 8'h11},
    {1'b0, 1'b1, 1'b0, 5'd1,  8'd255, 8'hA5},
    {1'b0, 1'b1, 1'b0, 5'd6,  8'd3,   8'h5C},
    {1'b0, 1'b1, 1'b0, 5'd3,  8'd255, 8'h00},
    {1'b1, 1'b0, 1'b1, 5'd4,  8'd255, 8'h22},
    {1'b1, 1'b0, 1'b1, 5'd5,  8'd20,  8'h77},
    {1'b1, 1'b0, 1'b0, 5'd3,  8'd255, 8'h3C},
    {1'b1, 1'b1, 1'b0, 5'd16, 8'd130, 8'h90},
    {1'b1, 1'b1, 1'b0, 5'd8,  8'd255, 8'hFF}
  };

  logic stream [0:319];
  int   nbits;

  function automatic logic [15:0] step(input logic [15:0] c, input logic b);
    logic fb = c[0] ^ b;
    c = c >> 1;
    if (fb) c = c ^ 16'h8408;
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // builds a frame: data, check characters, optional pad, optional flipped bit
  task automatic build(input bit sdlc, input int len, input logic [7:0] seed,
                       input bit pad, input int flip);
    logic [15:0] c = sdlc ? 16'hFFFF : 16'h0000;
    logic [15:0] fcs;
    nbits = 0;
    for (int k = 0; k < len; k++) begin
      logic [7:0] b = seed + 8'(k * 59) ^ 8'(k << 2);
      for (int i = 0; i < 8; i++) begin
        stream[nbits] = b[i];
        c = step(c, b[i]);
        nbits++;
      end
    end
    fcs = sdlc ? ~c : c;
    for (int i = 0; i < 16; i++) begin
      stream[nbits] = fcs[i];
      nbits++;
    end
    if (pad) for (int i = 0; i < 8; i++) begin
      stream[nbits] = 1'b0;
      nbits++;
    end
    if (flip < nbits) stream[flip] = ~stream[flip];
  endtask

  // expected verdict from R2/R3: what the register holds at the check point
  function automatic bit expect_err(input bit sdlc);
    logic [15:0] c = sdlc ? 16'hFFFF : 16'h0000;
    int upto = sdlc ? nbits : nbits - 8;
    for (int i = 0; i < upto; i++) c = step(c, stream[i]);
    return sdlc ? (c != 16'hF0B8) : (c != 16'h0000);
  endfunction

  task automatic send_bits();
    for (int i = 0; i < nbits; i++) begin
      bit_valid = 1'b1;
      bit_data  = stream[i];
      tick();
    end
    bit_valid = 1'b0;
    bit_data  = 1'b0;
  endtask

  task automatic end_frame(input string req, input bit exp);
    frame_end = 1'b1;
    tick();
    frame_end = 1'b0;
    chk(crc_done == 1'b1, "R7 done strobe", crc_done, 1);
    chk(crc_error == exp, req, crc_error, exp);
    tick();
    chk(crc_done == 1'b0, "R7 done one cycle", crc_done, 0);
  endtask

  task automatic run_frame(input string req, input bit exp);
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    send_bits();
    end_frame(req, exp);
  endtask

  task automatic pulse_cmd();
    crc_reset_cmd = 1'b1;
    tick();
    crc_reset_cmd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failed++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk(crc_error == 1'b0, "R10 error after reset", crc_error, 0);
    chk(crc_done == 1'b0, "R10 done after reset", crc_done, 0);
    chk(bit_ready == 1'b1, "R9 ready when enabled", bit_ready, 1);
    // R10 register starts at ones: good bit-oriented frame passes with no command
    build(1'b1, 2, 8'h6E, 1'b0, 255);
    run_frame("R10 preset ones at reset", expect_err(1'b1));

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] e = VEC[v];
      bit ex;
      sdlc_mode = e[22];
      tick();
      if (e[23]) pulse_cmd();
      build(e[22], int'(e[20:16]), e[7:0], e[21], int'(e[15:8]));
      ex = expect_err(e[22]);
      if (e[8 +: 8] != 8'd255) chk(ex == 1'b1, "R1 flip must be detected", ex, 1);
      if (e[22]) run_frame(e[23] ? "R2 bit-oriented verdict" : "R6 auto preset then R2", ex);
      else       run_frame(e[21] ? "R3 sync verdict with pad" : "R3 sync delay no pad", ex);
    end

    // R8: error held, then cleared by frame_start
    sdlc_mode = 1'b1;
    build(1'b1, 3, 8'h41, 1'b0, 5);
    run_frame("R2 corrupt frame", 1'b1);
    repeat (5) tick();
    chk(crc_error == 1'b1, "R8 error held", crc_error, 1);
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    chk(crc_error == 1'b0, "R8 cleared by frame_start", crc_error, 0);

    // R9: ready low while disabled and during frame_end
    rx_enable = 1'b0;
    #1 chk(bit_ready == 1'b0, "R9 ready low when disabled", bit_ready, 0);
    tick();
    rx_enable = 1'b1;
    frame_end = 1'b1;
    #1 chk(bit_ready == 1'b0, "R9 ready low at frame_end", bit_ready, 0);
    tick();
    frame_end = 1'b0;
    tick();

    // R9: bit offered at frame_end in sync mode is dropped
    sdlc_mode = 1'b0;
    tick();
    pulse_cmd();
    build(1'b0, 2, 8'h19, 1'b1, 255);
    run_frame("R3 sync good frame", 1'b0);
    frame_end = 1'b1;
    bit_valid = 1'b1;
    bit_data  = 1'b1;
    tick();
    frame_end = 1'b0;
    bit_valid = 1'b0;
    bit_data  = 1'b0;
    tick();
    for (int i = 0; i < 8; i++) stream[i] = 1'b0;
    nbits = 8;
    send_bits();
    end_frame("R9 bit at frame_end ignored", 1'b0);

    // R6: sync register is kept across frame_end
    pulse_cmd();
    build(1'b0, 3, 8'hC3, 1'b1, 9);
    run_frame("R3 sync corrupt", 1'b1);
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    chk(crc_error == 1'b0, "R8 cleared before recheck", crc_error, 0);
    end_frame("R6 sync register kept", 1'b1);

    // R5: receiver disable presets in sync mode
    build(1'b0, 4, 8'h5A, 1'b0, 255);
    send_bits();
    rx_enable = 1'b0;
    tick();
    rx_enable = 1'b1;
    build(1'b0, 2, 8'h81, 1'b1, 255);
    run_frame("R5 disable presets zeros", 1'b0);

    // R5: hunt presets in bit-oriented mode
    sdlc_mode = 1'b1;
    tick();
    build(1'b1, 3, 8'h2F, 1'b0, 255);
    nbits = 13;
    send_bits();
    hunt_pulse = 1'b1;
    tick();
    hunt_pulse = 1'b0;
    build(1'b1, 3, 8'h2F, 1'b0, 255);
    run_frame("R5 hunt presets ones", 1'b0);

    // R4: command presets ones in bit-oriented mode mid-frame
    build(1'b1, 2, 8'hE7, 1'b0, 255);
    nbits = 11;
    send_bits();
    pulse_cmd();
    build(1'b1, 2, 8'hE7, 1'b0, 255);
    run_frame("R4 command presets ones", 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule